// File: doc/BRIEF.md
# I2C Repeated-Start Sequencer

This block produces a repeated-start condition on an open-drain I2C line pair for a controller that can act as bus master. A one-cycle request strobe starts it. The request is taken only when the controller is idle and no other bus event is running. The sequence then steps through four phases:

1. Pull the clock line low.
2. Release the data line.
3. Release the clock line.
4. Pull the data line low while the clock line stays high.

Every phase waits until the line it drives reads back at the intended level. A reloadable down-counter sets the baud period of each timed phase.

Both line inputs pass through a two-flop synchronizer before the block uses them, so a slave that stretches the clock, or another master that drives the bus, is visible to the sequence. When the sequence completes, the data line stays pulled low for the transfer that follows, and a completion flag is raised. The block aborts with a bus-collision flag in two cases: the data line reads low when the clock line comes up, or the clock line is pulled low during the both-high period.

While the sequence runs, writes to the transmit byte register and to the five command bits are locked out. A transmit write in that window raises a write-collision flag instead of loading the byte.

Top module: `rsq_top`

## Requirements
- R1: After reset, `sda_oe` and `scl_oe` are 0, `busy` is 0, the flags `done_irq`, `bcol`, `wcol` and `start_seen` are 0, and `tx_byte` and `cmd_bits` are 0.
- R2: `rs_req` starts the sequence only when `busy` is 0 and `other_busy` is 0. In any other cycle it has no effect, and `busy`, `sda_oe` and `scl_oe` keep their values.
- R3: An accepted request sets `scl_oe` to 1 on the next edge. Once the synchronized clock line reads low, `sda_oe` goes to 0 and a count of `brg_reload`+1 cycles runs.
- R4: When that count has expired and the synchronized data line reads high, `scl_oe` goes to 0. The next count of `brg_reload`+1 cycles starts only once the synchronized clock line reads high, so a stretched clock holds the sequence.
- R5: After the both-high count, `sda_oe` goes to 1 for one more count of `brg_reload`+1 cycles. Then `busy` clears and `done_irq` sets, with `sda_oe` left at 1 and `scl_oe` at 0.
- R6: `start_seen` sets when two consecutive synchronized samples show the clock line high while the data line falls from 1 to 0.
- R7: `buf_wr` while `busy` is 1 sets `wcol` and leaves `tx_byte` unchanged. While idle, `buf_wr` loads `tx_byte` and leaves `wcol` unchanged.
- R8: `cmd_wr` while `busy` is 1 leaves `cmd_bits` unchanged. While idle, it loads the 5-bit `cmd_wdata`.
- R9: If the synchronized data line is low when the released clock line first reads high, the block sets `bcol`, drives both `sda_oe` and `scl_oe` to 0 and returns to idle without setting `done_irq`.
- R10: If the synchronized clock line reads low during the both-high count, the block sets `bcol`, drives both `sda_oe` and `scl_oe` to 0 and returns to idle.
- R11: `flag_clr` clears `done_irq`, `bcol`, `wcol` and `start_seen`. A flag that is set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rs_req | input | 1 | One-cycle repeated-start request strobe |
| other_busy | input | 1 | Another bus event of the controller is in progress |
| cmd_wr | input | 1 | Write strobe for the command bits |
| cmd_wdata | input | 5 | Command bit value to write |
| buf_wr | input | 1 | Write strobe for the transmit byte |
| buf_wdata | input | 8 | Transmit byte value to write |
| flag_clr | input | 1 | Clears all status flags |
| brg_reload | input | 7 | Baud reload value; one period is this value + 1 cycles |
| sda_in | input | 1 | Data line level read from the pin |
| scl_in | input | 1 | Clock line level read from the pin |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| scl_oe | output | 1 | 1 pulls the clock line low, 0 releases it |
| busy | output | 1 | The sequence is in progress |
| start_seen | output | 1 | A start condition was seen on the lines |
| done_irq | output | 1 | The sequence completed |
| wcol | output | 1 | Write collision on the transmit byte |
| bcol | output | 1 | Bus collision during the sequence |
| tx_byte | output | 8 | Transmit byte register |
| cmd_bits | output | 5 | Command bit register |

## Verification
The sequence is run with reload values 0, 3 and 10. With value 0 the timed phases end before the synchronizer has caught up with the released data line, so this case separates a design that waits for the line read-back from one that trusts the counter alone. With value 10, the length of the released-data phase is measured against reload+1.

A slave that stretches the clock shows whether the second count waits for the clock line to read high. Requests made while another event is busy, or while the sequence itself is running, show the idle gating. Two arbitration-loss patterns are driven: the data line held low across the clock rise, and the clock line pulled low in the both-high phase. They tell the two abort paths apart from a normal completion. A behavioural reference model runs beside the design and checks every output on every cycle.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SCL_LO  = 3'd1,
    ST_SDA_REL = 3'd2,
    ST_SCL_UP  = 3'd3,
    ST_BOTH_HI = 3'd4,
    ST_SDA_LO  = 3'd5
  } rs_state_t;

  // Start condition: data falls between two samples while clock stays high
  function automatic logic is_start(input logic sda_prev, input logic sda_now,
                                    input logic scl_prev, input logic scl_now);
    return sda_prev & ~sda_now & scl_prev & scl_now;
  endfunction

  // Timed phases are the ones where the baud counter runs
  function automatic logic is_timed(input rs_state_t s);
    return (s == ST_SDA_REL) || (s == ST_BOTH_HI) || (s == ST_SDA_LO);
  endfunction

endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b1;
        s2 <= 1'b1;
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/rsq_brg.sv
module rsq_brg #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          run,
  input  logic [CW-1:0] reload,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= reload;
    else if (run && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = run && (cnt == '0);
endmodule

// File: rtl/rsq_fsm.sv
module rsq_fsm
  import rsq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      go,
  input  logic      sda_s,
  input  logic      scl_s,
  input  logic      expired,
  output rs_state_t state,
  output logic      brg_load,
  output logic      brg_run,
  output logic      sda_drv,
  output logic      scl_drv,
  output logic      done_pulse,
  output logic      coll_pulse
);
  rs_state_t nxt;
  logic      sda_nxt, scl_nxt;

  always_comb begin
    nxt        = state;
    sda_nxt    = sda_drv;
    scl_nxt    = scl_drv;
    brg_load   = 1'b0;
    done_pulse = 1'b0;
    coll_pulse = 1'b0;
    unique case (state)
      ST_IDLE: if (go) begin
        nxt     = ST_SCL_LO;
        scl_nxt = 1'b1;
      end
      ST_SCL_LO: if (!scl_s) begin
        nxt      = ST_SDA_REL;
        sda_nxt  = 1'b0;
        brg_load = 1'b1;
      end
      ST_SDA_REL: if (expired && sda_s) begin
        nxt     = ST_SCL_UP;
        scl_nxt = 1'b0;
      end
      ST_SCL_UP: if (scl_s) begin
        if (!sda_s) coll_pulse = 1'b1;
        else begin
          nxt      = ST_BOTH_HI;
          brg_load = 1'b1;
        end
      end
      ST_BOTH_HI: begin
        if (!scl_s) coll_pulse = 1'b1;
        else if (expired) begin
          nxt      = ST_SDA_LO;
          sda_nxt  = 1'b1;
          brg_load = 1'b1;
        end
      end
      ST_SDA_LO: if (expired) begin
        nxt        = ST_IDLE;
        done_pulse = 1'b1;
      end
      default: nxt = ST_IDLE;
    endcase
    if (coll_pulse) begin
      nxt     = ST_IDLE;
      sda_nxt = 1'b0;
      scl_nxt = 1'b0;
    end
  end

  assign brg_run = is_timed(state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      sda_drv <= 1'b0;
      scl_drv <= 1'b0;
    end else begin
      state   <= nxt;
      sda_drv <= sda_nxt;
      scl_drv <= scl_nxt;
    end
  end
endmodule

// File: rtl/rsq_top.sv
module rsq_top
  import rsq_pkg::*;
#(
  parameter int BRG_W = 7,
  parameter int BUF_W = 8,
  parameter int CMD_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rs_req,
  input  logic             other_busy,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_wdata,
  input  logic             buf_wr,
  input  logic [BUF_W-1:0] buf_wdata,
  input  logic             flag_clr,
  input  logic [BRG_W-1:0] brg_reload,
  input  logic             sda_in,
  input  logic             scl_in,
  output logic             sda_oe,
  output logic             scl_oe,
  output logic             busy,
  output logic             start_seen,
  output logic             done_irq,
  output logic             wcol,
  output logic             bcol,
  output logic [BUF_W-1:0] tx_byte,
  output logic [CMD_W-1:0] cmd_bits
);
  logic [1:0] pins_s;
  logic       sda_s, scl_s, sda_p, scl_p;
  logic       accept, start_ev, expired, brg_load, brg_run;
  logic       done_pulse, coll_pulse;
  rs_state_t  state;

  rsq_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sda_in, scl_in}), .q(pins_s)
  );
  assign sda_s = pins_s[1];
  assign scl_s = pins_s[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_p <= 1'b1;
      scl_p <= 1'b1;
    end else begin
      sda_p <= sda_s;
      scl_p <= scl_s;
    end
  end

  assign start_ev = is_start(sda_p, sda_s, scl_p, scl_s);
  assign busy     = (state != ST_IDLE);
  assign accept   = rs_req && !busy && !other_busy;

  rsq_brg #(.CW(BRG_W)) u_brg (
    .clk(clk), .rst_n(rst_n), .load(brg_load), .run(brg_run),
    .reload(brg_reload), .expired(expired)
  );

  rsq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .go(accept), .sda_s(sda_s), .scl_s(scl_s),
    .expired(expired), .state(state), .brg_load(brg_load), .brg_run(brg_run),
    .sda_drv(sda_oe), .scl_drv(scl_oe), .done_pulse(done_pulse),
    .coll_pulse(coll_pulse)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_seen <= 1'b0;
      done_irq   <= 1'b0;
      wcol       <= 1'b0;
      bcol       <= 1'b0;
      tx_byte    <= '0;
      cmd_bits   <= '0;
    end else begin
      if (start_ev)        start_seen <= 1'b1;
      else if (flag_clr)   start_seen <= 1'b0;
      if (done_pulse)      done_irq <= 1'b1;
      else if (flag_clr)   done_irq <= 1'b0;
      if (coll_pulse)      bcol <= 1'b1;
      else if (flag_clr)   bcol <= 1'b0;
      if (buf_wr && busy)  wcol <= 1'b1;
      else if (flag_clr)   wcol <= 1'b0;
      if (buf_wr && !busy) tx_byte <= buf_wdata;
      if (cmd_wr && !busy) cmd_bits <= cmd_wdata;
    end
  end
endmodule

// File: rtl/rsq_chk.sv
module rsq_chk #(
  parameter int BRG_W = 7,
  parameter int BUF_W = 8,
  parameter int CMD_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rs_req,
  input logic             other_busy,
  input logic             cmd_wr,
  input logic             buf_wr,
  input logic             sda_oe,
  input logic             scl_oe,
  input logic             busy,
  input logic             done_irq,
  input logic             wcol,
  input logic             bcol,
  input logic [BUF_W-1:0] tx_byte,
  input logic [CMD_W-1:0] cmd_bits
);
  // R2
  idle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (other_busy || !rs_req)) |=> !busy);

  // R3
  scl_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> $past(rs_req && !other_busy && !busy));

  // R5
  done_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_irq) |-> (sda_oe && !scl_oe && !busy));

  // R7
  wcol_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && buf_wr) |=> (wcol && $stable(tx_byte)));

  // R8
  cmd_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |=> $stable(cmd_bits));

  // R9
  bcol_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bcol) |-> (!sda_oe && !scl_oe && !busy));
endmodule

bind rsq_top rsq_chk #(.BRG_W(BRG_W), .BUF_W(BUF_W), .CMD_W(CMD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rs_req(rs_req), .other_busy(other_busy),
  .cmd_wr(cmd_wr), .buf_wr(buf_wr), .sda_oe(sda_oe), .scl_oe(scl_oe),
  .busy(busy), .done_irq(done_irq), .wcol(wcol), .bcol(bcol),
  .tx_byte(tx_byte), .cmd_bits(cmd_bits)
);

// File: tb/rsq_top_tb.sv
`timescale 1ns/1ps
module rsq_top_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0, rs_req = 1'b0, other_busy = 1'b0, cmd_wr = 1'b0;
  logic [4:0] cmd_wdata = '0;
  logic       buf_wr = 1'b0, flag_clr = 1'b0;
  logic [7:0] buf_wdata = '0;
  logic [6:0] brg_reload = 7'd3;
  logic       ext_sda_lo = 1'b0, ext_scl_lo = 1'b0;
  wire        sda_pin, scl_pin;
  logic       sda_oe, scl_oe, busy, start_seen, done_irq, wcol, bcol;
  logic [7:0] tx_byte;
  logic [4:0] cmd_bits;

  assign sda_pin = ~(sda_oe | ext_sda_lo);
  assign scl_pin = ~(scl_oe | ext_scl_lo);

  rsq_top u_dut (
    .clk(clk), .rst_n(rst_n), .rs_req(rs_req), .other_busy(other_busy),
    .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .buf_wr(buf_wr),
    .buf_wdata(buf_wdata), .flag_clr(flag_clr), .brg_reload(brg_reload),
    .sda_in(sda_pin), .scl_in(scl_pin), .sda_oe(sda_oe), .scl_oe(scl_oe),
    .busy(busy), .start_seen(start_seen), .done_irq(done_irq), .wcol(wcol),
    .bcol(bcol), .tx_byte(tx_byte), .cmd_bits(cmd_bits)
  );

  int tests = 0, fails = 0;

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // phase: 0 idle, 1 wait clock low, 2 data released, 3 wait clock high,
  //        4 both high, 5 data low
  int   phase = 0, left = 0, model_fails = 0;
  bit   m_sda = 0, m_scl = 0, m_done = 0, m_bcol = 0, m_wcol = 0, m_ss = 0;
  int   m_buf = 0, m_cmd = 0;
  bit   hs[$], hc[$];
  // snapshots of what the design sees at the coming edge
  bit   p_rst = 0, p_req = 0, p_ob = 0, p_cwr = 0, p_bwr = 0, p_clr = 0;
  bit   p_sda = 1, p_scl = 1;
  int   p_cdata = 0, p_bdata = 0, p_reload = 0;

  always @(negedge clk) begin
    if (!p_rst) begin
      phase = 0; left = 0; m_sda = 0; m_scl = 0; m_done = 0; m_bcol = 0;
      m_wcol = 0; m_ss = 0; m_buf = 0; m_cmd = 0;
      hs = {1, 1, 1, 1}; hc = {1, 1, 1, 1};
    end else begin
      bit ds, cs, dp, cp, exp_now, was_busy, fin, abort, ld;
      hs.push_front(p_sda); void'(hs.pop_back());
      hc.push_front(p_scl); void'(hc.pop_back());
      ds = hs[2]; cs = hc[2]; dp = hs[3]; cp = hc[3];
      was_busy = (phase != 0);
      exp_now  = (phase == 2 || phase == 4 || phase == 5) && left == 0;
      fin = 0; abort = 0; ld = 0;
      if (phase == 0 && p_req && !p_ob) begin phase = 1; m_scl = 1; end
      else if (phase == 1 && !cs) begin phase = 2; m_sda = 0; ld = 1; end
      else if (phase == 2 && exp_now && ds) begin phase = 3; m_scl = 0; end
      else if (phase == 3 && cs) begin
        if (ds) begin phase = 4; ld = 1; end else abort = 1;
      end else if (phase == 4) begin
        if (!cs) abort = 1;
        else if (exp_now) begin phase = 5; m_sda = 1; ld = 1; end
      end else if (phase == 5 && exp_now) begin phase = 0; fin = 1; end
      if (ld) left = p_reload;
      else if ((phase == 2 || phase == 4 || phase == 5) && left > 0) left--;
      if (abort) begin phase = 0; m_sda = 0; m_scl = 0; end
      if (dp && !ds && cp && cs) m_ss = 1; else if (p_clr) m_ss = 0;
      if (fin) m_done = 1; else if (p_clr) m_done = 0;
      if (abort) m_bcol = 1; else if (p_clr) m_bcol = 0;
      if (p_bwr && was_busy) m_wcol = 1; else if (p_clr) m_wcol = 0;
      if (p_bwr && !was_busy) m_buf = p_bdata;
      if (p_cwr && !was_busy) m_cmd = p_cdata;
    end
    if (model_fails < 10) begin
      tests++;
      if ({sda_oe, scl_oe, busy, done_irq, bcol, wcol, start_seen} !==
          {m_sda, m_scl, (phase != 0), m_done, m_bcol, m_wcol, m_ss} ||
          int'(tx_byte) != m_buf || int'(cmd_bits) != m_cmd) begin
        fails++; model_fails++;
        $display("FAIL R3 model t=%0t: actual oe=%b%b busy=%b f=%b%b%b%b expected oe=%b%b busy=%b f=%b%b%b%b",
                 $time, sda_oe, scl_oe, busy, done_irq, bcol, wcol, start_seen,
                 m_sda, m_scl, phase != 0, m_done, m_bcol, m_wcol, m_ss);
      end
    end
    p_rst = rst_n; p_req = rs_req; p_ob = other_busy; p_cwr = cmd_wr;
    p_bwr = buf_wr; p_clr = flag_clr; p_sda = sda_pin; p_scl = scl_pin;
    p_cdata = cmd_wdata; p_bdata = buf_wdata; p_reload = brg_reload;
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic pulse_req();
    rs_req = 1'b1; tick(1); rs_req = 1'b0;
  endtask

  task automatic clear_flags();
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) tick(1);
  endtask

  task automatic wait_scl_released();
    for (int i = 0; i < 3000 && scl_oe; i++) tick(1);
  endtask

  int rel_cycles = 0;
  bit measure = 0;
  always @(negedge clk) if (measure && !sda_oe && scl_oe && busy) rel_cycles++;

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tick(4);
    // R1 reset state
    check("R1", "sda_oe", sda_oe, 0); check("R1", "scl_oe", scl_oe, 0);
    check("R1", "busy", busy, 0);
    check("R1", "flags", {done_irq, bcol, wcol, start_seen}, 0);
    check("R1", "tx_byte", tx_byte, 0);
    rst_n = 1'b1; tick(2);

    // R8 / R7 idle writes load
    cmd_wr = 1; cmd_wdata = 5'h15; buf_wr = 1; buf_wdata = 8'hA5; tick(1);
    cmd_wr = 0; buf_wr = 0; tick(1);
    check("R8", "idle cmd load", cmd_bits, 'h15);
    check("R7", "idle buf load", tx_byte, 'hA5);
    check("R7", "idle wcol", wcol, 0);

    // Normal sequence, reload 3, with locked-out writes and a second request
    brg_reload = 7'd3;
    pulse_req(); tick(3);
    check("R3", "busy after accept", busy, 1);
    check("R3", "scl pulled", scl_oe, 1);
    buf_wr = 1; buf_wdata = 8'h3C; cmd_wr = 1; cmd_wdata = 5'h0A; tick(1);
    buf_wr = 0; cmd_wr = 0; tick(1);
    check("R7", "busy wcol", wcol, 1);
    check("R7", "busy buf kept", tx_byte, 'hA5);
    check("R8", "busy cmd kept", cmd_bits, 'h15);
    pulse_req();
    wait_idle(); tick(1);
    check("R5", "done_irq", done_irq, 1);
    check("R5", "sda held", sda_oe, 1);
    check("R5", "scl released", scl_oe, 0);
    check("R6", "start_seen", start_seen, 1);
    check("R9", "no bcol", bcol, 0);

    // R11 clear
    clear_flags(); tick(1);
    check("R11", "flags cleared", {done_irq, bcol, wcol, start_seen}, 0);

    // R2 request ignored while another event runs
    other_busy = 1; pulse_req(); tick(5); other_busy = 0;
    check("R2", "busy stays low", busy, 0);
    check("R2", "sda unchanged", sda_oe, 1);
    check("R2", "scl unchanged", scl_oe, 0);

    // R3 / R4 reload 10 with clock stretching, measure released-data phase
    brg_reload = 7'd10; rel_cycles = 0; measure = 1;
    pulse_req(); ext_scl_lo = 1;
    wait_scl_released(); tick(8);
    check("R4", "held by stretch", busy, 1);
    check("R4", "no done during stretch", done_irq, 0);
    ext_scl_lo = 0;
    wait_idle(); tick(1); measure = 0;
    check("R3", "released-data cycles", rel_cycles, 11);
    check("R5", "done after stretch", done_irq, 1);
    clear_flags();

    // Reload 0
    brg_reload = 7'd0;
    pulse_req(); wait_idle(); tick(1);
    check("R5", "done reload 0", done_irq, 1);
    check("R5", "sda held reload 0", sda_oe, 1);
    clear_flags();

    // R9 data low when clock rises
    brg_reload = 7'd3;
    pulse_req(); ext_scl_lo = 1;
    wait_scl_released(); ext_sda_lo = 1; tick(4); ext_scl_lo = 0; tick(6);
    check("R9", "bcol", bcol, 1);
    check("R9", "lines released", {sda_oe, scl_oe}, 0);
    check("R9", "idle", busy, 0);
    check("R9", "no done", done_irq, 0);
    ext_sda_lo = 0; tick(3); clear_flags();

    // R10 clock pulled low during both-high
    brg_reload = 7'd10;
    pulse_req(); wait_scl_released(); tick(7);
    ext_scl_lo = 1; tick(4); ext_scl_lo = 0; tick(3);
    check("R10", "bcol", bcol, 1);
    check("R10", "lines released", {sda_oe, scl_oe}, 0);
    check("R10", "idle", busy, 0);
    check("R10", "no done", done_irq, 0);
    tick(4);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule